// File: doc/BRIEF.md
# Variable-Length CAN Receive Ring Buffer

This block holds accepted CAN frames in a byte-wide circular buffer, one variable-length record per frame. A store request presents a header byte, a 29-bit identifier and up to eight data bytes in a single cycle. The block packs them into a record of 3 to 13 bytes and appends it at the write pointer, but only when the whole record fits. The host reads the oldest record through a 13-byte window addressed relative to the start pointer. A release strobe then drops that record. The release length is decoded from the header byte stored at the start pointer.

A frame that does not fit is dropped whole and raises a sticky overrun flag, which a separate strobe clears. While the configuration-mode input is high, the message and byte counts are held at zero and stores are refused. Acceptance filtering and bit-level reception happen upstream.

Top module: `canrx_ring`

## Requirements
- R1: After a synchronous reset, rd_data, avail, overrun, msg_count and byte_count are all zero, and both pointers are zero.
- R2: A record whose header bit 7 is set (extended) is laid out as: header, ID[28:21], ID[20:13], ID[12:5], {ID[4:0],3'b000}, then the data bytes (st_data[7:0] first).
- R3: A record whose header bit 7 is clear (standard) is laid out as: header, ID[10:3], {ID[2:0],5'b00000}, then the data bytes.
- R4: Header bit 6 marks a remote frame, which is stored with no data bytes. The record length is 5 (extended) or 3 (standard), plus the data length code in header bits 3:0 when bit 6 is clear.
- R5: A store whose data length code exceeds 8 is ignored. No byte, count or flag changes.
- R6: A store whose record would take byte_count above the 64-byte capacity is dropped whole and sets overrun. A record that exactly fills the buffer is accepted.
- R7: clr_ovr clears overrun. An overflowing store in the same cycle wins, and overrun stays set.
- R8: A release while msg_count is zero has no effect.
- R9: A release advances the start pointer modulo 64 by the length decoded from the stored header at the start pointer. It lowers byte_count by that length and msg_count by one.
- R10: avail is high exactly while msg_count is non-zero. It rises with the first stored record and clears when the last one is released.
- R11: Window offset k (0 to 12) returns, one cycle later, the byte at (start + k) modulo 64. Offsets 13 to 15 return zero.
- R12: While cfg_mode is high, stores are ignored, both counts are forced to zero, and the start pointer is aligned to the write pointer.
- R13: A store and a release in the same cycle both take effect. The counts change by their net amount, and the overflow test uses the byte count from before the release.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_mode | input | 1 | Configuration mode: counts held at zero, stores refused |
| st_valid | input | 1 | Store request strobe |
| st_hdr | input | 8 | Record header: [7] extended, [6] remote, [3:0] data length code |
| st_id | input | 29 | Frame identifier (standard frames use bits 10:0) |
| st_data | input | 64 | Data bytes, byte 0 in bits 7:0 |
| rel | input | 1 | Release the oldest record |
| clr_ovr | input | 1 | Clear the overrun flag |
| win_addr | input | 4 | Window offset from the start pointer |
| rd_data | output | 8 | Registered window read data |
| avail | output | 1 | At least one record is stored |
| overrun | output | 1 | Sticky overrun flag |
| msg_count | output | 7 | Records stored |
| byte_count | output | 7 | Bytes occupied |

## Verification
On every cycle, the assertions check that the byte count never exceeds the capacity and that avail agrees with the message count. They also check the per-cycle effects of rejected length codes, overflowing stores, empty releases, overrun clearing and configuration mode. Record layout is checked only by the bench's reference model, through the read window. The same holds for the decoded release length, pointer wraparound and the net effect of a combined store and release. That model compares every output on every clock, during directed fill, drain and overflow scenarios and during a long random phase.

// File: rtl/canrx_pkg.sv
package canrx_pkg;
  localparam int REC_MAX = 13;
  localparam int LEN_W   = 5;

  // Record length in bytes, decoded from a header byte.
  function automatic logic [LEN_W-1:0] rec_len(input logic [7:0] h);
    logic [LEN_W-1:0] n;
    n = h[7] ? 5'd5 : 5'd3;
    if (!h[6]) n = n + {1'b0, h[3:0]};
    return n;
  endfunction

  function automatic logic dlc_ok(input logic [7:0] h);
    return h[3:0] <= 4'd8;
  endfunction
endpackage

// File: rtl/canrx_pack.sv
module canrx_pack (
  input  logic [7:0]        hdr,
  input  logic [28:0]       id,
  input  logic [63:0]       data,
  output logic [15:0][7:0]  rec
);
  always_comb begin
    rec    = '0;
    rec[0] = hdr;
    if (hdr[7]) begin
      rec[1] = id[28:21];
      rec[2] = id[20:13];
      rec[3] = id[12:5];
      rec[4] = {id[4:0], 3'b000};
      for (int i = 0; i < 8; i++) rec[5+i] = data[8*i +: 8];
    end else begin
      rec[1] = id[10:3];
      rec[2] = {id[2:0], 5'b00000};
      for (int i = 0; i < 8; i++) rec[3+i] = data[8*i +: 8];
    end
  end
endmodule

// File: rtl/canrx_store.sv
module canrx_store #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              we,
  input  logic [AW-1:0]     wptr,
  input  logic [4:0]        len,
  input  logic [15:0][7:0]  rec,
  input  logic [AW-1:0]     start,
  input  logic [3:0]        win_addr,
  output logic [7:0]        rd_data,
  output logic [7:0]        head_hdr
);
  logic [7:0]    mem  [DEPTH];
  logic [AW-1:0] offs [DEPTH];
  logic [DEPTH-1:0] wsel;

  // Each cell takes the record byte at its distance from the write pointer.
  for (genvar g = 0; g < DEPTH; g++) begin : g_sel
    assign offs[g] = AW'(g) - wptr;
    assign wsel[g] = we && (int'(offs[g]) < int'(len));
  end

  always_ff @(posedge clk) begin
    for (int g = 0; g < DEPTH; g++)
      if (wsel[g]) mem[g] <= rec[offs[g][3:0]];
  end

  always_ff @(posedge clk) begin
    if (rst)
      rd_data <= '0;
    else if (int'(win_addr) < canrx_pkg::REC_MAX)
      rd_data <= mem[start + AW'(win_addr)];
    else
      rd_data <= '0;
  end

  assign head_hdr = mem[start];
endmodule

// File: rtl/canrx_ctrl.sv
module canrx_ctrl #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_mode,
  input  logic          st_valid,
  input  logic [7:0]    st_hdr,
  input  logic          rel,
  input  logic          clr_ovr,
  input  logic [7:0]    head_hdr,
  output logic          wr_go,
  output logic [4:0]    st_len,
  output logic [AW-1:0] wptr,
  output logic [AW-1:0] start,
  output logic [CW-1:0] byte_count,
  output logic [CW-1:0] msg_count,
  output logic          avail,
  output logic          overrun
);
  import canrx_pkg::*;

  logic [4:0]    rel_len;
  logic [CW:0]   need;
  logic          accept, fits, ovf, rel_go;
  logic [CW-1:0] bc_n, mc_n;

  assign st_len  = rec_len(st_hdr);
  assign rel_len = rec_len(head_hdr);
  assign accept  = st_valid && !cfg_mode && dlc_ok(st_hdr);
  assign need    = {1'b0, byte_count} + (CW+1)'(st_len);
  assign fits    = need <= (CW+1)'(DEPTH);
  assign wr_go   = accept && fits;
  assign ovf     = accept && !fits;
  assign rel_go  = rel && !cfg_mode && (msg_count != '0);

  assign bc_n = byte_count + (wr_go ? CW'(st_len) : '0) - (rel_go ? CW'(rel_len) : '0);
  assign mc_n = msg_count + CW'(wr_go) - CW'(rel_go);

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr <= '0; start <= '0; byte_count <= '0; msg_count <= '0; avail <= 1'b0;
    end else if (cfg_mode) begin
      start <= wptr; byte_count <= '0; msg_count <= '0; avail <= 1'b0;
    end else begin
      if (wr_go)  wptr  <= wptr + AW'(st_len);
      if (rel_go) start <= start + AW'(rel_len);
      byte_count <= bc_n;
      msg_count  <= mc_n;
      avail      <= (mc_n != '0);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)          overrun <= 1'b0;
    else if (ovf)     overrun <= 1'b1;
    else if (clr_ovr) overrun <= 1'b0;
  end
endmodule

// File: rtl/canrx_ring.sv
module canrx_ring #(
  parameter int DEPTH = 64,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          cfg_mode,
  input  logic          st_valid,
  input  logic [7:0]    st_hdr,
  input  logic [28:0]   st_id,
  input  logic [63:0]   st_data,
  input  logic          rel,
  input  logic          clr_ovr,
  input  logic [3:0]    win_addr,
  output logic [7:0]    rd_data,
  output logic          avail,
  output logic          overrun,
  output logic [CW-1:0] msg_count,
  output logic [CW-1:0] byte_count
);
  logic [15:0][7:0] rec;
  logic             wr_go;
  logic [4:0]       st_len;
  logic [AW-1:0]    wptr, start;
  logic [7:0]       head_hdr;

  canrx_pack u_pack (.hdr(st_hdr), .id(st_id), .data(st_data), .rec(rec));

  canrx_ctrl #(.DEPTH(DEPTH)) u_ctrl (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .st_valid(st_valid), .st_hdr(st_hdr),
    .rel(rel), .clr_ovr(clr_ovr), .head_hdr(head_hdr), .wr_go(wr_go), .st_len(st_len),
    .wptr(wptr), .start(start), .byte_count(byte_count), .msg_count(msg_count),
    .avail(avail), .overrun(overrun)
  );

  canrx_store #(.DEPTH(DEPTH)) u_store (
    .clk(clk), .rst(rst), .we(wr_go), .wptr(wptr), .len(st_len), .rec(rec),
    .start(start), .win_addr(win_addr), .rd_data(rd_data), .head_hdr(head_hdr)
  );
endmodule

// File: rtl/canrx_ring_chk.sv
module canrx_ring_chk #(
  parameter int DEPTH = 64,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input logic          clk,
  input logic          rst,
  input logic          cfg_mode,
  input logic          st_valid,
  input logic [7:0]    st_hdr,
  input logic          rel,
  input logic          clr_ovr,
  input logic          avail,
  input logic          overrun,
  input logic [CW-1:0] msg_count,
  input logic [CW-1:0] byte_count
);
  // R6
  cnt_bound_chk: assert property (@(posedge clk) disable iff (rst)
    int'(byte_count) <= DEPTH);

  // R10
  avail_match_chk: assert property (@(posedge clk) disable iff (rst)
    avail == (msg_count != '0));

  // R8
  rel_empty_chk: assert property (@(posedge clk) disable iff (rst)
    (rel && msg_count == '0 && !st_valid && !cfg_mode) |=> (msg_count == '0 && byte_count == '0));

  // R5
  bad_dlc_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && st_hdr[3:0] > 4'd8 && !rel && !cfg_mode) |=> ($stable(byte_count) && $stable(msg_count)));

  // R6
  ovf_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (st_valid && !cfg_mode && st_hdr[3:0] <= 4'd8 &&
     (int'(byte_count) + int'(canrx_pkg::rec_len(st_hdr)) > DEPTH)) |=> overrun);

  // R12
  cfg_clear_chk: assert property (@(posedge clk) disable iff (rst)
    cfg_mode |=> (msg_count == '0 && byte_count == '0));

  // R7
  ovr_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (clr_ovr && !st_valid) |=> !overrun);
endmodule

bind canrx_ring canrx_ring_chk #(.DEPTH(DEPTH)) u_chk (
  .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .st_valid(st_valid), .st_hdr(st_hdr),
  .rel(rel), .clr_ovr(clr_ovr), .avail(avail), .overrun(overrun),
  .msg_count(msg_count), .byte_count(byte_count)
);

// File: tb/canrx_ring_bench.sv
`timescale 1ns/1ps
module canrx_ring_bench;
  localparam int DEPTH = 64;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic cfg_mode = 1'b0, st_valid = 1'b0, rel = 1'b0, clr_ovr = 1'b0;
  logic [7:0]  st_hdr = '0;
  logic [28:0] st_id = '0;
  logic [63:0] st_data = '0;
  logic [3:0]  win_addr = '0;
  logic [7:0]  rd_data;
  logic        avail, overrun;
  logic [6:0]  msg_count, byte_count;

  int checks = 0, errors = 0, cycles = 0;
  bit win_rand = 1'b1;
  logic [3:0] win_fix = '0;

  always #2.5 clk = ~clk;

  canrx_ring u_canrx_ring (
    .clk(clk), .rst(rst), .cfg_mode(cfg_mode), .st_valid(st_valid), .st_hdr(st_hdr),
    .st_id(st_id), .st_data(st_data), .rel(rel), .clr_ovr(clr_ovr), .win_addr(win_addr),
    .rd_data(rd_data), .avail(avail), .overrun(overrun), .msg_count(msg_count),
    .byte_count(byte_count)
  );

  // ---------------- reference model ----------------
  int  q[$];
  int  mstart = 0, mwptr = 0;
  bit  movr = 0;
  byte unsigned mmem [DEPTH];
  bit  mvalid [DEPTH];
  int  exp_rd = 0;
  bit  rd_cmp = 0, ready = 0;

  function automatic int rlen(input logic [7:0] h);
    return (h[7] ? 5 : 3) + (h[6] ? 0 : int'(h[3:0]));
  endfunction

  function automatic int byte_at(input logic [7:0] h, input logic [28:0] id,
                                 input logic [63:0] d, input int k);
    int hd;
    if (k == 0) return int'(h);
    hd = h[7] ? 5 : 3;
    if (k >= hd) return int'((d >> (8*(k-hd))) & 64'hFF);
    if (h[7]) begin
      case (k)
        1: return int'((id >> 21) & 255);
        2: return int'((id >> 13) & 255);
        3: return int'((id >> 5) & 255);
        default: return int'((id & 31) << 3);
      endcase
    end
    if (k == 1) return int'((id >> 3) & 255);
    return int'((id & 7) << 5);
  endfunction

  function automatic int qsum();
    int s = 0;
    foreach (q[i]) s += q[i];
    return s;
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      q.delete(); mstart = 0; mwptr = 0; movr = 0; exp_rd = 0; rd_cmp = 1; ready = 1;
      for (int i = 0; i < DEPTH; i++) mvalid[i] = 0;
    end else if (ready) begin
      int a, idx, len, cb, rl;
      bit acc, fit, rok;
      a = int'(win_addr);
      idx = (mstart + a) % DEPTH;
      if (a < 13) begin rd_cmp = mvalid[idx]; exp_rd = mmem[idx]; end
      else begin rd_cmp = 1; exp_rd = 0; end
      cb = qsum();
      len = rlen(st_hdr);
      if (cfg_mode) begin
        q.delete(); mstart = mwptr;
        if (clr_ovr) movr = 0;
      end else begin
        acc = st_valid && (st_hdr[3:0] <= 8);
        fit = (cb + len) <= DEPTH;
        rok = rel && (q.size() > 0);
        rl  = rok ? q[0] : 0;
        if (acc && fit) begin
          for (int k = 0; k < len; k++) begin
            mmem[(mwptr + k) % DEPTH]   = byte'(byte_at(st_hdr, st_id, st_data, k));
            mvalid[(mwptr + k) % DEPTH] = 1;
          end
          mwptr = (mwptr + len) % DEPTH;
        end
        if (rok) begin
          mstart = (mstart + rl) % DEPTH;
          void'(q.pop_front());
        end
        if (acc && fit) q.push_back(len);
        if (acc && !fit) movr = 1;
        else if (clr_ovr) movr = 0;
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // per-cycle comparison against the model
  always @(negedge clk) begin
    if (ready) begin
      chk("R10 avail", int'(avail), int'(q.size() > 0));
      chk("R9 msg_count", int'(msg_count), q.size());
      chk("R9 byte_count", int'(byte_count), qsum());
      chk("R6 overrun", int'(overrun), int'(movr));
      if (rd_cmp) chk("R11 rd_data", int'(rd_data), exp_rd);
    end
    win_addr <= win_rand ? 4'($urandom % 16) : win_fix;
  end

  // watchdog
  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      errors++; checks++;
      $display("FAIL watchdog actual %0d expected %0d", cycles, 150000);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic drive(input bit sv, input logic [7:0] h, input logic [28:0] id,
                       input logic [63:0] d, input bit r, input bit c);
    st_valid = sv; st_hdr = h; st_id = id; st_data = d; rel = r; clr_ovr = c;
    @(negedge clk);
    st_valid = 0; rel = 0; clr_ovr = 0;
  endtask

  task automatic rd_win(input int k, output int v);
    win_rand = 0; win_fix = 4'(k);
    idle(3);
    v = int'(rd_data);
    win_rand = 1;
  endtask

  initial begin
    int v;
    repeat (3) @(negedge clk);
    rst = 0;
    // R1
    chk("R1 msg_count", int'(msg_count), 0);
    chk("R1 byte_count", int'(byte_count), 0);
    chk("R1 avail", int'(avail), 0);
    chk("R1 overrun", int'(overrun), 0);

    // R2: extended data frame, dlc 3
    drive(1, 8'h83, 29'h1234567, 64'h00000000_00CCBBAA, 0, 0);
    chk("R10 avail set", int'(avail), 1);
    chk("R4 ext len", int'(byte_count), 8);
    rd_win(0, v);  chk("R2 hdr", v, 8'h83);
    rd_win(1, v);  chk("R2 id hi", v, int'((29'h1234567 >> 21) & 255));
    rd_win(4, v);  chk("R2 id lo", v, int'((29'h1234567 & 31) << 3));
    rd_win(5, v);  chk("R2 data0", v, 8'hAA);
    rd_win(14, v); chk("R11 out of window", v, 0);

    // R3: release, then standard frame
    drive(0, 0, 0, 0, 1, 0);
    chk("R10 avail clear", int'(avail), 0);
    drive(1, 8'h02, 29'h5A3, 64'h0000_0000_0000_7711, 0, 0);
    rd_win(1, v); chk("R3 id hi", v, 8'hB4);
    rd_win(2, v); chk("R3 id lo", v, 8'h60);
    rd_win(4, v); chk("R3 data1", v, 8'h77);
    drive(0, 0, 0, 0, 1, 0);

    // R4: remote extended dlc 4 -> 5 bytes
    drive(1, 8'hC4, 29'h1ABCDEF, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0);
    chk("R4 remote len", int'(byte_count), 5);
    // R5: dlc 9 rejected
    drive(1, 8'h09, 29'h7FF, 0, 0, 0);
    chk("R5 bytes", int'(byte_count), 5);
    chk("R5 msgs", int'(msg_count), 1);
    chk("R5 no overrun", int'(overrun), 0);
    // R8 setup: drain, then release on empty
    drive(0, 0, 0, 0, 1, 0);
    drive(0, 0, 0, 0, 1, 0);
    chk("R8 empty bytes", int'(byte_count), 0);
    chk("R8 empty msgs", int'(msg_count), 0);

    // R6: fill to exactly 64 (4x13 + 12), then overflow
    for (int i = 0; i < 4; i++) drive(1, 8'h88, 29'(i * 1000), 64'h1122334455667788, 0, 0);
    drive(1, 8'h87, 29'h55, 64'h0102030405060708, 0, 0);
    chk("R6 exact fit", int'(byte_count), 64);
    drive(1, 8'h40, 29'h1, 0, 0, 0);
    chk("R6 drop", int'(msg_count), 5);
    chk("R6 flag", int'(overrun), 1);
    // R7: clear and overflow together -> stays set; then plain clear
    drive(1, 8'h40, 29'h1, 0, 0, 1);
    chk("R7 set wins", int'(overrun), 1);
    drive(0, 0, 0, 0, 0, 1);
    chk("R7 clear", int'(overrun), 0);
    // R13: store (len 3) with release (len 13) from full: overflow test uses pre-release count
    drive(1, 8'h00, 29'h3, 0, 1, 0);
    chk("R13 overflow before release", int'(byte_count), 51);
    drive(1, 8'h00, 29'h3, 0, 1, 0);
    chk("R13 net bytes", int'(byte_count), 41);
    chk("R13 net msgs", int'(msg_count), 4);
    // R9: drain across the wrap
    for (int i = 0; i < 4; i++) drive(0, 0, 0, 0, 1, 0);
    chk("R9 drained", int'(byte_count), 0);

    // R12: configuration mode
    drive(1, 8'h01, 29'h10, 64'h5, 0, 0);
    cfg_mode = 1;
    drive(1, 8'h01, 29'h10, 64'h5, 0, 0);
    chk("R12 counts", int'(byte_count), 0);
    chk("R12 msgs", int'(msg_count), 0);
    cfg_mode = 0;
    drive(1, 8'h01, 29'h2A, 64'h99, 0, 0);
    rd_win(3, v); chk("R12 aligned", v, 8'h99);

    // random phase
    for (int n = 0; n < 4000; n++) begin
      logic [7:0] h;
      h = 8'($urandom);
      h[3:0] = 4'($urandom % 10);
      cfg_mode = ($urandom % 100) < 2;
      drive(($urandom % 10) < 4, h, 29'($urandom), {32'($urandom), 32'($urandom)},
            ($urandom % 10) < 3, ($urandom % 20) == 0);
    end
    cfg_mode = 0;
    idle(4);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule